// File: doc/BRIEF.md
# Region-Based Physical Access Permission Checker

This block sits beside a processor pipeline and decides whether one memory access may go ahead. Each request carries a 34-bit physical byte address, an access kind (instruction fetch, data load or data store) and the privilege of the requester. The checker compares the request against a bank of protection regions. Each region has an 8-bit configuration byte and a 32-bit boundary word. The boundary word holds address bits 33..2.

The checker matches the region bank in three ways: an arbitrary top-of-range span, a single aligned word, and a naturally aligned power-of-two block whose size comes from the trailing ones of the boundary word. The lowest-numbered region that matches decides the outcome. The result is registered and appears as three separate fault flags, one per access kind, so the pipeline can raise a precise access-fault exception with the right cause. Only the base address of an access is checked. Machine-mode requests bypass every region that is not locked.

Top module: `pmp_access_checker`

## Requirements
- R1: Results are registered. `rsp_valid` equals `req_valid` from the previous clock edge. All fault flags are 0 when `rsp_valid` is 0. A synchronous active-high `rst` clears `rsp_valid` and every fault flag.
- R2: Region i uses bits [8i+7:8i] of `region_cfg` and bits [32i+31:32i] of `region_addr`. In the configuration byte, bit 0 permits loads, bit 1 permits stores, bit 2 permits fetches, bits 4:3 select the match mode (0 off, 1 top-of-range, 2 single word, 3 power-of-two block), and bit 7 is the lock.
- R3: Top-of-range mode matches byte addresses from region i-1's boundary word shifted left by 2 (inclusive) up to region i's own boundary word shifted left by 2 (exclusive). Region 0 uses 0 as its lower bound.
- R4: Single-word mode matches only the 4-byte aligned word whose address bits 33..2 equal the boundary word.
- R5: Power-of-two mode with n trailing ones in the boundary word matches a block of 2^(n+3) bytes. The block's base is the boundary word with those n ones and the next bit cleared, shifted left by 2.
- R6: When several regions match, the lowest-numbered one decides the outcome. A region in off mode never matches.
- R7: The access kind is encoded as 0 fetch, 1 load, 2 store, 3 no access. A fetch checks only the fetch permission, a load only the load permission and a store only the store permission. Kind 3 never faults.
- R8: When no region matches, a request with `req_mmode`=0 faults and a request with `req_mmode`=1 is allowed.
- R9: A machine-mode request that matches an unlocked region is allowed whatever that region's permissions are. A locked region is enforced on machine mode.
- R10: A denied fetch raises only `fetch_fault`, a denied load only `load_fault` and a denied store only `store_fault`. At most one flag is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 34 | Physical byte address of the access |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 none |
| req_mmode | input | 1 | Requester runs in machine mode |
| region_cfg | input | 8*N_REGIONS | Configuration bytes, region 0 in the lowest byte |
| region_addr | input | 32*N_REGIONS | Boundary words (address bits 33..2), region 0 lowest |
| rsp_valid | output | 1 | Result present, one cycle after the request |
| fetch_fault | output | 1 | Instruction fetch denied |
| load_fault | output | 1 | Load denied |
| store_fault | output | 1 | Store denied |

## Verification
The region match, the priority pick and the permission decision are all combinational, and a single output register follows them. Every result is therefore due exactly one clock edge after the request. The bench drives each request on a falling edge and samples `rsp_valid` and the three flags on the next falling edge, which lies after the one capturing edge and before the following one. Configuration changes are made while no request is in flight. Each check therefore reflects exactly one request under one known region setup.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    MM_OFF   = 2'd0,
    MM_TOR   = 2'd1,
    MM_WORD  = 2'd2,
    MM_BLOCK = 2'd3
  } match_mode_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    logic [1:0] mode;
    logic       perm_x;
    logic       perm_w;
    logic       perm_r;
  } region_cfg_t;

  localparam int CFG_W = 8;

endpackage

// File: rtl/pmpc_region_match.sv
module pmpc_region_match import pmpc_pkg::*; #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_addr,
  input  logic [WORD_W-1:0] own_bound,
  input  logic [WORD_W-1:0] prev_bound,
  input  logic [1:0]        mode,
  output logic              hit
);

  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  logic [WORD_W-1:0] block_mask;
  logic              tor_hit;
  logic              word_hit;
  logic              block_hit;

  // ones over the trailing-one run plus the following zero bit
  assign block_mask = own_bound ^ (own_bound + ONE);

  assign tor_hit   = (word_addr >= prev_bound) && (word_addr < own_bound);
  assign word_hit  = (word_addr == own_bound);
  assign block_hit = ((word_addr ^ own_bound) & ~block_mask) == '0;

  always_comb begin
    unique case (match_mode_e'(mode))
      MM_TOR:   hit = tor_hit;
      MM_WORD:  hit = word_hit;
      MM_BLOCK: hit = block_hit;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmpc_prio_select.sv
module pmpc_prio_select import pmpc_pkg::*; #(
  parameter int N_REGIONS = 16
) (
  input  logic [N_REGIONS-1:0] hits,
  input  logic [N_REGIONS-1:0] lock_v,
  input  logic [N_REGIONS-1:0] perm_x_v,
  input  logic [N_REGIONS-1:0] perm_w_v,
  input  logic [N_REGIONS-1:0] perm_r_v,
  output logic                 any_hit,
  output logic                 sel_lock,
  output logic                 sel_x,
  output logic                 sel_w,
  output logic                 sel_r
);

  // scan from the top down so the lowest index is written last
  always_comb begin
    any_hit  = 1'b0;
    sel_lock = 1'b0;
    sel_x    = 1'b0;
    sel_w    = 1'b0;
    sel_r    = 1'b0;
    for (int i = N_REGIONS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit  = 1'b1;
        sel_lock = lock_v[i];
        sel_x    = perm_x_v[i];
        sel_w    = perm_w_v[i];
        sel_r    = perm_r_v[i];
      end
    end
  end

endmodule

// File: rtl/pmpc_perm_eval.sv
module pmpc_perm_eval import pmpc_pkg::*; (
  input  logic       any_hit,
  input  logic       sel_lock,
  input  logic       sel_x,
  input  logic       sel_w,
  input  logic       sel_r,
  input  logic       mmode,
  input  logic [1:0] kind,
  output logic       deny_fetch,
  output logic       deny_load,
  output logic       deny_store
);

  logic enforce;
  logic granted_x;
  logic granted_w;
  logic granted_r;

  assign enforce = !mmode || sel_lock;

  always_comb begin
    if (any_hit) begin
      granted_x = !enforce || sel_x;
      granted_w = !enforce || sel_w;
      granted_r = !enforce || sel_r;
    end else begin
      granted_x = mmode;
      granted_w = mmode;
      granted_r = mmode;
    end
  end

  always_comb begin
    deny_fetch = 1'b0;
    deny_load  = 1'b0;
    deny_store = 1'b0;
    unique case (acc_kind_e'(kind))
      ACC_FETCH: deny_fetch = !granted_x;
      ACC_LOAD:  deny_load  = !granted_r;
      ACC_STORE: deny_store = !granted_w;
      default:   ;
    endcase
  end

endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker import pmpc_pkg::*; #(
  parameter int N_REGIONS = 16,
  parameter int PA_W      = 34
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic [PA_W-1:0]                req_addr,
  input  logic [1:0]                     req_kind,
  input  logic                           req_mmode,
  input  logic [N_REGIONS*CFG_W-1:0]     region_cfg,
  input  logic [N_REGIONS*(PA_W-2)-1:0]  region_addr,
  output logic                           rsp_valid,
  output logic                           fetch_fault,
  output logic                           load_fault,
  output logic                           store_fault
);

  localparam int WORD_W = PA_W - 2;

  logic [WORD_W-1:0]    word_addr;
  logic [N_REGIONS-1:0] hits;
  logic [N_REGIONS-1:0] lock_v;
  logic [N_REGIONS-1:0] perm_x_v;
  logic [N_REGIONS-1:0] perm_w_v;
  logic [N_REGIONS-1:0] perm_r_v;
  logic [N_REGIONS-1:0] rsvd_any;

  assign word_addr = req_addr[PA_W-1:2];

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
    region_cfg_t       cfg_g;
    logic [WORD_W-1:0] own_b;
    logic [WORD_W-1:0] prev_b;

    assign cfg_g = region_cfg_t'(region_cfg[g*CFG_W +: CFG_W]);
    assign own_b = region_addr[g*WORD_W +: WORD_W];

    if (g == 0) begin : g_first
      assign prev_b = '0;
    end else begin : g_rest
      assign prev_b = region_addr[(g-1)*WORD_W +: WORD_W];
    end

    assign lock_v[g]   = cfg_g.lock;
    assign perm_x_v[g] = cfg_g.perm_x;
    assign perm_w_v[g] = cfg_g.perm_w;
    assign perm_r_v[g] = cfg_g.perm_r;
    assign rsvd_any[g] = |cfg_g.rsvd;

    pmpc_region_match #(.WORD_W(WORD_W)) i_match (
      .word_addr  (word_addr),
      .own_bound  (own_b),
      .prev_bound (prev_b),
      .mode       (cfg_g.mode),
      .hit        (hits[g])
    );
  end

  logic any_hit, sel_lock, sel_x, sel_w, sel_r;
  logic deny_fetch, deny_load, deny_store;

  pmpc_prio_select #(.N_REGIONS(N_REGIONS)) i_prio (
    .hits     (hits),
    .lock_v   (lock_v),
    .perm_x_v (perm_x_v),
    .perm_w_v (perm_w_v),
    .perm_r_v (perm_r_v),
    .any_hit  (any_hit),
    .sel_lock (sel_lock),
    .sel_x    (sel_x),
    .sel_w    (sel_w),
    .sel_r    (sel_r)
  );

  pmpc_perm_eval i_eval (
    .any_hit    (any_hit),
    .sel_lock   (sel_lock),
    .sel_x      (sel_x),
    .sel_w      (sel_w),
    .sel_r      (sel_r),
    .mmode      (req_mmode),
    .kind       (req_kind),
    .deny_fetch (deny_fetch),
    .deny_load  (deny_load),
    .deny_store (deny_store)
  );

  // reserved configuration bits carry no meaning
  logic unused_rsvd;
  assign unused_rsvd = |rsvd_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      fetch_fault <= 1'b0;
      load_fault  <= 1'b0;
      store_fault <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      fetch_fault <= req_valid && deny_fetch;
      load_fault  <= req_valid && deny_load;
      store_fault <= req_valid && deny_store;
    end
  end

endmodule

// File: rtl/pmpc_checker.sv
module pmpc_checker import pmpc_pkg::*; #(
  parameter int N_REGIONS = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic [1:0]                 req_kind,
  input logic                       req_mmode,
  input logic [N_REGIONS*CFG_W-1:0] region_cfg,
  input logic                       rsp_valid,
  input logic                       fetch_fault,
  input logic                       load_fault,
  input logic                       store_fault
);

  logic [N_REGIONS-1:0] locks;
  for (genvar g = 0; g < N_REGIONS; g++) begin : g_lock
    assign locks[g] = region_cfg[g*CFG_W + CFG_W - 1];
  end

  logic any_fault;
  assign any_fault = fetch_fault || load_fault || store_fault;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !any_fault));

  a_r10_single_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetch_fault, load_fault, store_fault}));

  a_r7_load_kind: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == ACC_LOAD) |=> (!fetch_fault && !store_fault));

  a_r7_store_kind: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == ACC_STORE) |=> (!fetch_fault && !load_fault));

  a_r7_none_kind: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == ACC_NONE) |=> !any_fault);

  a_r9_mmode_unlocked: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mmode && locks == '0) |=> !any_fault);

endmodule

bind pmp_access_checker pmpc_checker #(.N_REGIONS(N_REGIONS)) i_pmpc_checker (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_kind    (req_kind),
  .req_mmode   (req_mmode),
  .region_cfg  (region_cfg),
  .rsp_valid   (rsp_valid),
  .fetch_fault (fetch_fault),
  .load_fault  (load_fault),
  .store_fault (store_fault)
);

// File: tb/test_pmp_access_checker.sv
module test_pmp_access_checker;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 16;
  localparam int PA_W = 34;
  localparam int WW = PA_W - 2;

  localparam logic [1:0] K_F = 2'd0;
  localparam logic [1:0] K_L = 2'd1;
  localparam logic [1:0] K_S = 2'd2;
  localparam logic [1:0] K_N = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [PA_W-1:0] req_addr = '0;
  logic [1:0] req_kind = '0;
  logic req_mmode = 1'b0;
  logic [NR*8-1:0] region_cfg = '0;
  logic [NR*WW-1:0] region_addr = '0;
  logic rsp_valid, fetch_fault, load_fault, store_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_access_checker #(.N_REGIONS(NR), .PA_W(PA_W)) i_pmp_access_checker (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_addr (req_addr),
    .req_kind (req_kind), .req_mmode (req_mmode), .region_cfg (region_cfg),
    .region_addr (region_addr), .rsp_valid (rsp_valid),
    .fetch_fault (fetch_fault), .load_fault (load_fault), .store_fault (store_fault)
  );

  task automatic set_region(input int idx, input logic [7:0] cfg, input logic [WW-1:0] bnd);
    region_cfg[idx*8 +: 8]    = cfg;
    region_addr[idx*WW +: WW] = bnd;
  endtask

  task automatic check_out(input string tag, input logic exp_v,
                           input logic ef, input logic el, input logic es);
    checks++;
    if ({rsp_valid, fetch_fault, load_fault, store_fault} !== {exp_v, ef, el, es}) begin
      errors++;
      $display("FAIL %s: got v=%b f=%b l=%b s=%b expected v=%b f=%b l=%b s=%b",
               tag, rsp_valid, fetch_fault, load_fault, store_fault, exp_v, ef, el, es);
    end
  endtask

  // drive on a falling edge, result is registered at the next rising edge
  task automatic access(input string tag, input logic [PA_W-1:0] a, input logic [1:0] k,
                        input logic m, input logic exp_fault);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_kind  = k;
    req_mmode = m;
    @(negedge clk);
    req_valid = 1'b0;
    check_out(tag, 1'b1, exp_fault && k == K_F, exp_fault && k == K_L, exp_fault && k == K_S);
  endtask

  task automatic t_reset;
    check_out("R1 reset state", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = 34'h3_8000_0000;
    req_kind  = K_L;
    req_mmode = 1'b0;
    @(negedge clk);
    check_out("R1 no request no flags", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_tor;
    access("R3 tor r0 load low", 34'h0, K_L, 1'b0, 1'b0);
    access("R3 tor r0 fetch top word", 34'h0FFFC, K_F, 1'b0, 1'b0);
    access("R3 tor r0 store denied", 34'h0FFFC, K_S, 1'b0, 1'b1);
    access("R3 tor r1 store at lower bound", 34'h10000, K_S, 1'b0, 1'b0);
    access("R3 tor r1 fetch denied", 34'h10000, K_F, 1'b0, 1'b1);
    access("R3 tor r1 last word store", 34'h17FFC, K_S, 1'b0, 1'b0);
    access("R3 tor r1 upper bound excluded", 34'h18000, K_F, 1'b0, 1'b0);
  endtask

  task automatic t_word;
    access("R4 word load denied", 34'h20000, K_L, 1'b0, 1'b1);
    access("R4 word store allowed", 34'h20000, K_S, 1'b0, 1'b0);
    access("R4 unaligned base in word", 34'h20003, K_L, 1'b0, 1'b1);
    access("R4 next word not matched", 34'h20004, K_L, 1'b0, 1'b0);
  endtask

  task automatic t_block;
    access("R5 block base fetch", 34'h2000_0000, K_F, 1'b0, 1'b0);
    access("R5 block load denied", 34'h2000_0000, K_L, 1'b0, 1'b1);
    access("R5 block last word load denied", 34'h2000_7FFC, K_L, 1'b0, 1'b1);
    access("R5 past block end", 34'h2000_8000, K_L, 1'b0, 1'b0);
    access("R5 below block base", 34'h1FFF_FFFC, K_L, 1'b0, 1'b0);
  endtask

  task automatic t_prio;
    access("R6 r0 beats wide r4 store", 34'h100, K_S, 1'b0, 1'b1);
    access("R6 wide r4 alone", 34'h3000_0000, K_S, 1'b0, 1'b0);
    access("R6 off region never matches", 34'h3_8000_0000, K_L, 1'b0, 1'b1);
  endtask

  task automatic t_kind;
    access("R7 none kind no fault", 34'h3_8000_0000, K_N, 1'b0, 1'b0);
    access("R10 fetch flag only", 34'h3_8000_0000, K_F, 1'b0, 1'b1);
    access("R10 store flag only", 34'h3_8000_0000, K_S, 1'b0, 1'b1);
  endtask

  task automatic t_priv;
    access("R8 user unmatched faults", 34'h3_0000_0004, K_L, 1'b0, 1'b1);
    access("R8 machine unmatched allowed", 34'h3_0000_0004, K_L, 1'b1, 1'b0);
    access("R9 machine unlocked bypass", 34'h100, K_S, 1'b1, 1'b0);
    access("R9 machine locked enforced", 34'h3_0000_0000, K_L, 1'b1, 1'b1);
    access("R9 user locked enforced", 34'h3_0000_0000, K_F, 1'b0, 1'b1);
  endtask

  initial begin
    // R2 layout: bit0 R, bit1 W, bit2 X, bits4:3 mode, bit7 lock
    set_region(0, 8'h0D, 32'h0000_4000);   // top-of-range, R+X
    set_region(1, 8'h0B, 32'h0000_6000);   // top-of-range, R+W
    set_region(2, 8'h12, 32'h0000_8000);   // single word, W
    set_region(3, 8'h1C, 32'h0800_0FFF);   // 32 KiB block, X
    set_region(4, 8'h1F, 32'h07FF_FFFF);   // 1 GiB block, R+W+X
    set_region(5, 8'h90, 32'hC000_0000);   // locked single word, none
    set_region(6, 8'h07, 32'hFFFF_FFFF);   // off, would cover all
    repeat (2) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_idle();
    t_tor();
    t_word();
    t_block();
    t_prio();
    t_kind();
    t_priv();
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule